// File: doc/BRIEF.md
# Lane-Fragment Signed 8-bit Matrix Multiply-Accumulate Tile

This block computes D = A*B + C for one tile. A is an 8x16 matrix of signed 8-bit values, B is a 16x8 matrix of signed 8-bit values, and C and D are 8x8 matrices of 32-bit values. The operands are not written as plain matrices. They arrive as the per-lane register fragments of a 32-lane group. Each lane writes one packed A word, one packed B word and a pair of accumulator words through a lane-indexed load port. The block places every byte and word in its matrix position by decoding the lane number. A sits row-major and B sits column-major, so one lane's A word and B word cover the same run of four K indices.

A start pulse begins the compute phase. The block takes one K step per cycle and updates all 64 accumulators in parallel on each step. The tile therefore completes after 16 steps, and a one-cycle done pulse marks the end. The results are then read back two words at a time through a lane-indexed read port that uses the same lane-to-position mapping as the accumulator load.

Top module: `lmma_s8_tile`

## Requirements
- R1: After a run, every result element D[m][n] equals C[m][n] plus the sum over k = 0..15 of A[m][k]*B[k][n]. A and B elements are treated as signed two's-complement bytes.
- R2: Accumulation wraps modulo 2^32 and never saturates.
- R3: For load lane t, ld_a supplies A row t/4 at K indices 4*(t%4)+i. Byte i (bits 8i+7..8i) holds index i, so byte 0 carries the lowest K index.
- R4: For load lane t, ld_b supplies B column t/4 at K indices 4*(t%4)+i, using the same byte order as ld_a.
- R5: For lane t, ld_c0 and ld_c1 write accumulator row t/4 at columns 2*(t%4) and 2*(t%4)+1. rd_d0 and rd_d1 return those same two positions for rd_lane = t.
- R6: A start pulse sampled while idle raises busy on the next edge. busy stays high for 16 cycles. done is high for exactly one cycle, starting on the same edge where busy falls.
- R7: Loads presented while busy are ignored and do not change any operand or accumulator.
- R8: A start pulse presented while busy is ignored. It neither restarts nor extends the run, and it produces no second done pulse.
- R9: After reset, busy and done are low.
- R10: Results stay unchanged on the read port after done until the next load or start. The read port is combinational from rd_lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one lane's fragments |
| ld_lane | input | 5 | Lane number for the load |
| ld_a | input | 32 | Packed four A bytes |
| ld_b | input | 32 | Packed four B bytes |
| ld_c0 | input | 32 | Accumulator at the lane's even column |
| ld_c1 | input | 32 | Accumulator at the lane's odd column |
| start | input | 1 | Begin the compute phase |
| busy | output | 1 | Compute phase in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_lane | input | 5 | Lane number for the result read |
| rd_d0 | output | 32 | Result at the lane's even column |
| rd_d1 | output | 32 | Result at the lane's odd column |

## Verification
On every cycle the assertions check the control timing: done lasts one cycle, busy falls only together with done, and a start while busy lets the K step advance without restarting it. They also check that operand storage holds still for the whole busy window and that accumulators move only on a step or an idle load. The arithmetic cannot be shown by these properties, and neither can the lane-to-element decoding of A, B, C and D. The bench shows both with directed selector patterns, extreme values that force wrap-around, and pseudo-random tiles, comparing all 64 results against a reference product computed in the bench.

// File: rtl/lmma_pkg.sv
package lmma_pkg;
    parameter int LANES = 32;
    parameter int TM    = 8;
    parameter int TN    = 8;
    parameter int TK    = 16;
    parameter int EW    = 8;
    parameter int AW    = 32;

    localparam int LW  = $clog2(LANES);
    localparam int KW  = $clog2(TK);
    localparam int KPL = AW / EW;       // K elements packed per lane word
    localparam int LPR = TK / KPL;      // lanes sharing one row or column
    localparam int CPL = TN / LPR;      // accumulator words per lane

    typedef logic signed [EW-1:0] elem_t;
    typedef logic [AW-1:0]        acc_t;
endpackage

// File: rtl/lmma_ctrl.sv
module lmma_ctrl
    import lmma_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic [KW-1:0] k_idx
);
    typedef struct packed {
        logic          busy;
        logic          done;
        logic [KW-1:0] k;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.k    = '0;
            end
        end else begin
            st_d.k = st_q.k + KW'(1);
            if (st_q.k == KW'(TK-1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy  = st_q.busy;
    assign done  = st_q.done;
    assign k_idx = st_q.k;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && k_idx != KW'(TK-1)) |=> (busy && k_idx == $past(k_idx) + KW'(1)));
endmodule

// File: rtl/lmma_opnd.sv
module lmma_opnd
    import lmma_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          busy,
    input  logic [LW-1:0] lane,
    input  logic [AW-1:0] a_word,
    input  logic [AW-1:0] b_word,
    input  logic [KW-1:0] k_idx,
    output elem_t         a_vec [TM],
    output elem_t         b_vec [TN]
);
    typedef struct packed {
        logic [TM-1:0][TK-1:0][EW-1:0] a;
        logic [TK-1:0][TN-1:0][EW-1:0] b;
    } opnd_t;

    opnd_t op_d, op_q;

    always_comb begin
        int row;
        int kb;
        op_d = op_q;
        row  = int'(lane) / LPR;
        kb   = KPL * (int'(lane) % LPR);
        if (wr_en) begin
            for (int i = 0; i < KPL; i++) begin
                op_d.a[row][kb+i] = a_word[i*EW +: EW];
                op_d.b[kb+i][row] = b_word[i*EW +: EW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) op_q <= '0;
        else        op_q <= op_d;
    end

    for (genvar m = 0; m < TM; m++) begin : g_acol
        assign a_vec[m] = elem_t'(op_q.a[m][k_idx]);
    end
    for (genvar n = 0; n < TN; n++) begin : g_brow
        assign b_vec[n] = elem_t'(op_q.b[k_idx][n]);
    end

    // R7
    opnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(op_q));
endmodule

// File: rtl/lmma_acc.sv
module lmma_acc
    import lmma_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          step,
    input  logic [LW-1:0] lane,
    input  logic [AW-1:0] c0,
    input  logic [AW-1:0] c1,
    input  elem_t         a_vec [TM],
    input  elem_t         b_vec [TN],
    input  logic [LW-1:0] rd_lane,
    output logic [AW-1:0] rd0,
    output logic [AW-1:0] rd1
);
    typedef struct packed {
        logic [TM-1:0][TN-1:0][AW-1:0] acc;
    } acc_arr_t;

    acc_arr_t ac_d, ac_q;

    function automatic acc_t mul_ext(elem_t x, elem_t y);
        logic signed [2*EW-1:0] p;
        p = x * y;
        return {{(AW-2*EW){p[2*EW-1]}}, p};
    endfunction

    always_comb begin
        int row;
        int col;
        ac_d = ac_q;
        row  = int'(lane) / LPR;
        col  = CPL * (int'(lane) % LPR);
        if (step) begin
            for (int m = 0; m < TM; m++)
                for (int n = 0; n < TN; n++)
                    ac_d.acc[m][n] = ac_q.acc[m][n] + mul_ext(a_vec[m], b_vec[n]);
        end else if (wr_en) begin
            ac_d.acc[row][col]   = c0;
            ac_d.acc[row][col+1] = c1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ac_q <= '0;
        else        ac_q <= ac_d;
    end

    always_comb begin
        int rr;
        int rc;
        rr  = int'(rd_lane) / LPR;
        rc  = CPL * (int'(rd_lane) % LPR);
        rd0 = ac_q.acc[rr][rc];
        rd1 = ac_q.acc[rr][rc+1];
    end

    // R10
    acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_en) |=> $stable(ac_q));
endmodule

// File: rtl/lmma_s8_tile.sv
module lmma_s8_tile
    import lmma_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [LW-1:0] ld_lane,
    input  logic [AW-1:0] ld_a,
    input  logic [AW-1:0] ld_b,
    input  logic [AW-1:0] ld_c0,
    input  logic [AW-1:0] ld_c1,
    input  logic          start,
    output logic          busy,
    output logic          done,
    input  logic [LW-1:0] rd_lane,
    output logic [AW-1:0] rd_d0,
    output logic [AW-1:0] rd_d1
);
    logic          busy_w;
    logic          wr_ok;
    logic [KW-1:0] k_idx;
    elem_t         a_vec [TM];
    elem_t         b_vec [TN];

    assign wr_ok = ld_en && !busy_w;

    lmma_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy_w), .done(done), .k_idx(k_idx)
    );

    lmma_opnd u_opnd (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .busy(busy_w),
        .lane(ld_lane), .a_word(ld_a), .b_word(ld_b), .k_idx(k_idx),
        .a_vec(a_vec), .b_vec(b_vec)
    );

    lmma_acc u_acc (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .step(busy_w),
        .lane(ld_lane), .c0(ld_c0), .c1(ld_c1),
        .a_vec(a_vec), .b_vec(b_vec),
        .rd_lane(rd_lane), .rd0(rd_d0), .rd1(rd_d1)
    );

    assign busy = busy_w;
endmodule

// File: tb/sim_lmma_s8_tile.sv
`timescale 1ns/1ps
module sim_lmma_s8_tile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [4:0]  ld_lane = '0;
    logic [31:0] ld_a = '0, ld_b = '0, ld_c0 = '0, ld_c1 = '0;
    logic        start = 1'b0;
    logic        busy, done;
    logic [4:0]  rd_lane = '0;
    logic [31:0] rd_d0, rd_d1;

    int checks = 0;
    int errors = 0;
    int ra [8][16];
    int rb [16][8];
    logic [31:0] rc [8][8];
    int seed = 12345;

    always #2.5 clk = ~clk;

    lmma_s8_tile u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_lane(ld_lane),
        .ld_a(ld_a), .ld_b(ld_b), .ld_c0(ld_c0), .ld_c1(ld_c1),
        .start(start), .busy(busy), .done(done),
        .rd_lane(rd_lane), .rd_d0(rd_d0), .rd_d1(rd_d1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int rnd8();
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 16) & 255) - 128;
    endfunction

    function automatic logic [31:0] ref_d(int m, int n);
        logic [31:0] s;
        s = rc[m][n];
        for (int k = 0; k < 16; k++) s = s + 32'(ra[m][k] * rb[k][n]);
        return s;
    endfunction

    task automatic load_all();
        for (int t = 0; t < 32; t++) begin
            int row = t / 4;
            int kb = 4 * (t % 4);
            @(negedge clk);
            ld_en = 1'b1;
            ld_lane = 5'(t);
            for (int i = 0; i < 4; i++) begin
                ld_a[i*8 +: 8] = 8'(ra[row][kb+i]);
                ld_b[i*8 +: 8] = 8'(rb[kb+i][row]);
            end
            ld_c0 = rc[row][2*(t%4)];
            ld_c1 = rc[row][2*(t%4)+1];
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_check(input bit inject, input string req);
        int cnt;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        chk("R6 busy after start", 32'(busy), 32'd1);
        while (!done && cnt < 100) begin
            if (inject && cnt == 3) begin
                ld_en = 1'b1; ld_lane = 5'd0;
                ld_a = 32'h7f7f7f7f; ld_b = 32'h81818181;
                ld_c0 = 32'hdeadbeef; ld_c1 = 32'h12345678;
                start = 1'b1;
            end else begin
                ld_en = 1'b0; start = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        ld_en = 1'b0; start = 1'b0;
        chk("R6 done latency", 32'(cnt), 32'd17);
        chk("R6 busy low with done", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R6 done one cycle", 32'(done), 32'd0);
        if (inject) begin
            int extra = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (done || busy) extra++;
            end
            chk("R8 no second run", 32'(extra), 32'd0);
        end
        for (int t = 0; t < 32; t++) begin
            rd_lane = 5'(t);
            #0.1;
            chk({req, " R5 d0"}, rd_d0, ref_d(t/4, 2*(t%4)));
            chk({req, " R5 d1"}, rd_d1, ref_d(t/4, 2*(t%4)+1));
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9
        chk("R9 busy reset", 32'(busy), 32'd0);
        chk("R9 done reset", 32'(done), 32'd0);
        rst_n = 1'b1;

        // R5: zero operands, result equals loaded accumulator
        for (int m = 0; m < 8; m++) for (int k = 0; k < 16; k++) ra[m][k] = 0;
        for (int k = 0; k < 16; k++) for (int n = 0; n < 8; n++) rb[k][n] = 0;
        for (int m = 0; m < 8; m++) for (int n = 0; n < 8; n++) rc[m][n] = 32'(m*100 + n);
        load_all();
        run_check(1'b0, "R5 C passthrough");

        // R3: B selects low K, D = A[m][n] + C
        for (int m = 0; m < 8; m++) for (int k = 0; k < 16; k++) ra[m][k] = m*16 + k - 64;
        for (int k = 0; k < 16; k++) for (int n = 0; n < 8; n++) rb[k][n] = (k == n) ? 1 : 0;
        load_all();
        run_check(1'b0, "R3 A lane map");

        // R3: B selects high K
        for (int k = 0; k < 16; k++) for (int n = 0; n < 8; n++) rb[k][n] = (k == n + 8) ? 1 : 0;
        load_all();
        run_check(1'b0, "R3 A high bytes");

        // R4: A selects B rows 8..15, D = B[m+8][n] + C
        for (int m = 0; m < 8; m++) for (int k = 0; k < 16; k++) ra[m][k] = (k == m + 8) ? 1 : 0;
        for (int k = 0; k < 16; k++) for (int n = 0; n < 8; n++) rb[k][n] = k*8 + n - 70;
        load_all();
        run_check(1'b0, "R4 B lane map");

        // R2: extremes force wrap past 2^31
        for (int m = 0; m < 8; m++) for (int k = 0; k < 16; k++) ra[m][k] = -128;
        for (int k = 0; k < 16; k++) for (int n = 0; n < 8; n++) rb[k][n] = (n % 2) ? 127 : -128;
        for (int m = 0; m < 8; m++) for (int n = 0; n < 8; n++) rc[m][n] = (n % 2) ? 32'h80000000 : 32'h7fffffff;
        load_all();
        run_check(1'b0, "R2 wrap");

        // R1: pseudo-random tiles
        for (int r = 0; r < 3; r++) begin
            for (int m = 0; m < 8; m++) for (int k = 0; k < 16; k++) ra[m][k] = rnd8();
            for (int k = 0; k < 16; k++) for (int n = 0; n < 8; n++) rb[k][n] = rnd8();
            for (int m = 0; m < 8; m++) for (int n = 0; n < 8; n++)
                rc[m][n] = {8'(rnd8()), 8'(rnd8()), 8'(rnd8()), 8'(rnd8())};
            load_all();
            run_check(1'b0, "R1 random");
        end

        // R7 R8 R10: load and start while busy are ignored, results hold
        load_all();
        run_check(1'b1, "R7 R10 busy load");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule